// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Generator

This block watches the list registers that a hypervisor fills with virtual interrupt entries for each physical CPU and raises a level-sensitive maintenance interrupt when the hypervisor has asked to be told about a condition. For every CPU it reduces its list entries to three counts: entries that want an end-of-interrupt notification, entries that hold a live interrupt, and entries that are waiting as pending. It combines these counts with a per-CPU hypervisor control word and with the group enables of that CPU's virtual interface to form an 8-bit status word.

Software writes list entries and control words through two register-style write ports. A read port returns the status word of a selected CPU with no side effect. The status word and the interrupt lines are combinational functions of the stored registers and the group-enable inputs. A change therefore shows up right after the clock edge that stores a write, or right after the group enable moves.

Field layout. In a list entry, bits [29:28] hold the state (00 invalid, 01 pending, 10 active, 11 pending and active), bit 31 is the hardware-linked flag and bit 19 requests EOI notification. In a control word, bit 0 is the global enable, bits 1 to 7 are the condition enables, and bits [31:27] hold the EOI count. In the status word, bit 0 is EOI, bit 1 underflow, bit 2 entry-not-present, bit 3 no-pending, bit 4 group 0 on, bit 5 group 0 off, bit 6 group 1 on and bit 7 group 1 off.

Top module: `vmaint_gen`

## Requirements
- R1: After reset every list entry and control word is zero, so every status word reads 0x00 and every maintenance line is low.
- R2: Status bit 0 is set when at least one list entry of that CPU has state 00, bit 31 clear and bit 19 set. No control bit gates it.
- R3: Status bit 1 is set exactly when control bit 1 is set and fewer than two list entries of that CPU have a state other than 00.
- R4: Status bit 2 is set exactly when control bit 2 is set and control field [31:27] is nonzero.
- R5: Status bit 3 is set exactly when control bit 3 is set and no list entry of that CPU has state exactly 01.
- R6: Status bits 4 and 5 are control bits 4 and 5, gated by the CPU's group 0 enable input being high or low. Status bits 6 and 7 are control bits 6 and 7, gated by the group 1 enable input being high or low.
- R7: A CPU's maintenance line is high exactly when its control bit 0 is set and its status word is nonzero. The line is a level: it stays high for as long as the condition lasts.
- R8: A write is stored at the clock edge where its write enable is high, and the status reflects it immediately after that edge. A control word or list entry does not change in a cycle without a write to it.
- R9: Reading the status of one CPU does not change any stored state or any other CPU's result.
- R10: A write to one CPU's list entry or control word leaves every other CPU's status and maintenance line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_we | input | 1 | List entry write enable |
| lr_cpu | input | CPU_W | CPU whose list entry is written |
| lr_idx | input | LR_W | Index of the list entry written |
| lr_wdata | input | 32 | List entry write data |
| hcr_we | input | 1 | Control word write enable |
| hcr_cpu | input | CPU_W | CPU whose control word is written |
| hcr_wdata | input | 32 | Control word write data |
| vif_grp0_en | input | NUM_CPU | Group 0 enable of each CPU's virtual interface |
| vif_grp1_en | input | NUM_CPU | Group 1 enable of each CPU's virtual interface |
| rd_cpu | input | CPU_W | CPU selected on the status read port |
| rd_status | output | 8 | Status word of the selected CPU |
| maint_irq | output | NUM_CPU | Level maintenance interrupt, one per CPU |

## Verification
On every cycle the assertions check the implications that must hold in any state. An interrupt line is never high without the global enable and a nonzero status. Underflow and entry-not-present never appear with their enables clear. The two group 0 bits are never both set. EOI is never reported without an EOI entry, and a control word stays unchanged in a cycle without a write to it. The exact count thresholds cannot be shown by these implications alone: that underflow clears at the second live entry, that the hardware-linked flag and a non-invalid state both block EOI, that no-pending tracks state 01 only, and that CPUs are independent. These are shown by the bench's directed corner cases and its randomized writes, which compare every CPU's status and line against a reference model after each write.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;

  typedef logic [31:0] lr_entry_t;
  typedef logic [31:0] hcr_word_t;
  typedef logic [7:0]  mstat_t;

  localparam int LR_HW_BIT     = 31;
  localparam int LR_NOTIFY_BIT = 19;
  localparam int LR_STATE_LO   = 28;

  localparam logic [1:0] ST_INVALID = 2'b00;
  localparam logic [1:0] ST_PENDING = 2'b01;

  localparam int HC_GLOBAL   = 0;
  localparam int HC_UNDER    = 1;
  localparam int HC_ENP      = 2;
  localparam int HC_NOPEND   = 3;
  localparam int HC_G0ON     = 4;
  localparam int HC_G0OFF    = 5;
  localparam int HC_G1ON     = 6;
  localparam int HC_G1OFF    = 7;
  localparam int HC_CNT_LO   = 27;

  function automatic logic [1:0] lr_state(input lr_entry_t e);
    return e[LR_STATE_LO +: 2];
  endfunction

  function automatic logic lr_wants_eoi(input lr_entry_t e);
    return (lr_state(e) == ST_INVALID) && !e[LR_HW_BIT] && e[LR_NOTIFY_BIT];
  endfunction

endpackage

// File: rtl/vm_reg_bank.sv
module vm_reg_bank #(
  parameter int N   = 4,
  parameter int W   = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q [N]
);

  logic [W-1:0] d [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    logic hit;
    assign hit = we && (int'(idx) == g);

    always_comb begin
      d[g] = q[g];
      if (hit) d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= d[g];
    end
  end

endmodule

// File: rtl/vm_lr_tally.sv
module vm_lr_tally
  import vmaint_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  lr_entry_t        entries [NUM_LR],
  output logic [CNT_W-1:0] eoi_cnt,
  output logic [CNT_W-1:0] valid_cnt,
  output logic [CNT_W-1:0] pend_cnt
);

  always_comb begin
    eoi_cnt   = '0;
    valid_cnt = '0;
    pend_cnt  = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (lr_wants_eoi(entries[i]))             eoi_cnt   = eoi_cnt + CNT_W'(1);
      if (lr_state(entries[i]) != ST_INVALID)   valid_cnt = valid_cnt + CNT_W'(1);
      if (lr_state(entries[i]) == ST_PENDING)   pend_cnt  = pend_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/vm_status_word.sv
module vm_status_word
  import vmaint_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] eoi_cnt,
  input  logic [CNT_W-1:0] valid_cnt,
  input  logic [CNT_W-1:0] pend_cnt,
  input  hcr_word_t        hcr,
  input  logic             grp0_en,
  input  logic             grp1_en,
  output mstat_t           status,
  output logic             irq
);

  always_comb begin
    status    = '0;
    status[0] = (eoi_cnt != '0);
    status[1] = hcr[HC_UNDER]  && (int'(valid_cnt) < 2);
    status[2] = hcr[HC_ENP]    && (hcr[HC_CNT_LO +: 5] != 5'd0);
    status[3] = hcr[HC_NOPEND] && (pend_cnt == '0);
    status[4] = hcr[HC_G0ON]   &&  grp0_en;
    status[5] = hcr[HC_G0OFF]  && !grp0_en;
    status[6] = hcr[HC_G1ON]   &&  grp1_en;
    status[7] = hcr[HC_G1OFF]  && !grp1_en;
    irq       = hcr[HC_GLOBAL] && (status != '0);
  end

endmodule

// File: rtl/vmaint_gen.sv
module vmaint_gen
  import vmaint_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_LR  = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lr_we,
  input  logic [CPU_W-1:0]   lr_cpu,
  input  logic [LR_W-1:0]    lr_idx,
  input  logic [31:0]        lr_wdata,
  input  logic               hcr_we,
  input  logic [CPU_W-1:0]   hcr_cpu,
  input  logic [31:0]        hcr_wdata,
  input  logic [NUM_CPU-1:0] vif_grp0_en,
  input  logic [NUM_CPU-1:0] vif_grp1_en,
  input  logic [CPU_W-1:0]   rd_cpu,
  output logic [7:0]         rd_status,
  output logic [NUM_CPU-1:0] maint_irq
);

  localparam int NUM_ENT = NUM_CPU * NUM_LR;
  localparam int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W   = $clog2(NUM_LR + 1);

  // flat list-entry write index, guarded against out-of-range selectors
  logic             lr_sel_ok;
  logic             lr_bank_we;
  logic [ENT_W-1:0] lr_flat_idx;
  logic             hcr_sel_ok;
  logic             hcr_bank_we;

  always_comb begin
    lr_sel_ok   = (int'(lr_cpu) < NUM_CPU) && (int'(lr_idx) < NUM_LR);
    lr_bank_we  = lr_we && lr_sel_ok;
    lr_flat_idx = ENT_W'(int'(lr_cpu) * NUM_LR + int'(lr_idx));
    hcr_sel_ok  = (int'(hcr_cpu) < NUM_CPU);
    hcr_bank_we = hcr_we && hcr_sel_ok;
  end

  lr_entry_t lr_q  [NUM_ENT];
  hcr_word_t hcr_q [NUM_CPU];

  vm_reg_bank #(.N(NUM_ENT), .W(32)) u_lr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lr_bank_we),
    .idx   (lr_flat_idx),
    .wdata (lr_wdata),
    .q     (lr_q)
  );

  vm_reg_bank #(.N(NUM_CPU), .W(32)) u_hcr_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (hcr_bank_we),
    .idx   (hcr_cpu),
    .wdata (hcr_wdata),
    .q     (hcr_q)
  );

  mstat_t status_c [NUM_CPU];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    lr_entry_t        lr_row [NUM_LR];
    logic [CNT_W-1:0] n_eoi;
    logic [CNT_W-1:0] n_valid;
    logic [CNT_W-1:0] n_pend;
    logic             irq_c;

    for (genvar l = 0; l < NUM_LR; l++) begin : g_row
      assign lr_row[l] = lr_q[c*NUM_LR + l];
    end

    vm_lr_tally #(.NUM_LR(NUM_LR)) u_tally (
      .entries   (lr_row),
      .eoi_cnt   (n_eoi),
      .valid_cnt (n_valid),
      .pend_cnt  (n_pend)
    );

    vm_status_word #(.CNT_W(CNT_W)) u_stat (
      .eoi_cnt   (n_eoi),
      .valid_cnt (n_valid),
      .pend_cnt  (n_pend),
      .hcr       (hcr_q[c]),
      .grp0_en   (vif_grp0_en[c]),
      .grp1_en   (vif_grp1_en[c]),
      .status    (status_c[c]),
      .irq       (irq_c)
    );

    assign maint_irq[c] = irq_c;

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      maint_irq[c] |-> hcr_q[c][HC_GLOBAL]); // R7
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      maint_irq[c] |-> (status_c[c] != '0)); // R7
    AST_EOI_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      status_c[c][0] |-> (n_eoi != '0)); // R2
    AST_UNDER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      status_c[c][1] |-> hcr_q[c][HC_UNDER]); // R3
    AST_ENP_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      status_c[c][2] |-> (hcr_q[c][HC_CNT_LO +: 5] != 5'd0)); // R4
    AST_NOPEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      status_c[c][3] |-> (n_pend == '0)); // R5
    AST_GRP0_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_c[c][4] && status_c[c][5])); // R6
    AST_HCR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !hcr_we |=> $stable(hcr_q[c])); // R8
  end

  always_comb begin
    rd_status = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (int'(rd_cpu) == c) rd_status = status_c[c];
    end
  end

endmodule

// File: tb/vmaint_gen_bench.sv
module vmaint_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NL = 4;

  logic          clk;
  logic          rst_n;
  logic          lr_we;
  logic [0:0]    lr_cpu;
  logic [1:0]    lr_idx;
  logic [31:0]   lr_wdata;
  logic          hcr_we;
  logic [0:0]    hcr_cpu;
  logic [31:0]   hcr_wdata;
  logic [NC-1:0] g0, g1;
  logic [0:0]    rd_cpu;
  logic [7:0]    rd_status;
  logic [NC-1:0] maint_irq;

  vmaint_gen #(.NUM_CPU(NC), .NUM_LR(NL)) u_vmaint_gen (
    .clk(clk), .rst_n(rst_n),
    .lr_we(lr_we), .lr_cpu(lr_cpu), .lr_idx(lr_idx), .lr_wdata(lr_wdata),
    .hcr_we(hcr_we), .hcr_cpu(hcr_cpu), .hcr_wdata(hcr_wdata),
    .vif_grp0_en(g0), .vif_grp1_en(g1),
    .rd_cpu(rd_cpu), .rd_status(rd_status), .maint_irq(maint_irq)
  );

  logic [31:0] m_lr  [NC][NL];
  logic [31:0] m_hcr [NC];
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] exp_status(int c);
    int ne = 0, nv = 0, np = 0;
    logic [7:0] s;
    logic [31:0] h;
    h = m_hcr[c];
    for (int i = 0; i < NL; i++) begin
      logic [1:0] st;
      st = m_lr[c][i][29:28];
      if (st == 2'b00 && !m_lr[c][i][31] && m_lr[c][i][19]) ne++;
      if (st != 2'b00) nv++;
      if (st == 2'b01) np++;
    end
    s[0] = ne != 0;
    s[1] = h[1] && nv < 2;
    s[2] = h[2] && h[31:27] != 0;
    s[3] = h[3] && np == 0;
    s[4] = h[4] && g0[c];
    s[5] = h[5] && !g0[c];
    s[6] = h[6] && g1[c];
    s[7] = h[7] && !g1[c];
    return s;
  endfunction

  function automatic string bit_req(int b);
    case (b)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // sample every CPU away from the clock edge
  task automatic check_all(string ctx);
    for (int c = 0; c < NC; c++) begin
      logic [7:0] e;
      logic ei;
      rd_cpu = c[0:0];
      #1;
      e  = exp_status(c);
      ei = m_hcr[c][0] && (e != 0);
      n_checks++;
      if (rd_status !== e) begin
        n_fail++;
        for (int b = 0; b < 8; b++)
          if (rd_status[b] !== e[b]) begin
            $display("FAIL %s %s cpu%0d status: actual=%02h expected=%02h", bit_req(b), ctx, c, rd_status, e);
            break;
          end
      end
      n_checks++;
      if (maint_irq[c] !== ei) begin
        n_fail++;
        $display("FAIL R7 %s cpu%0d irq: actual=%0b expected=%0b", ctx, c, maint_irq[c], ei);
      end
    end
  endtask

  task automatic wr_lr(int c, int i, logic [31:0] d);
    @(negedge clk);
    lr_we = 1; lr_cpu = c[0:0]; lr_idx = i[1:0]; lr_wdata = d;
    @(negedge clk);
    lr_we = 0;
    m_lr[c][i] = d;
  endtask

  task automatic wr_hcr(int c, logic [31:0] d);
    @(negedge clk);
    hcr_we = 1; hcr_cpu = c[0:0]; hcr_wdata = d;
    @(negedge clk);
    hcr_we = 0;
    m_hcr[c] = d;
  endtask

  function automatic logic [31:0] mk_lr(logic hw, logic [1:0] st, logic notify);
    logic [31:0] v;
    v = 32'h0;
    v[31] = hw; v[29:28] = st; v[19] = notify;
    return v;
  endfunction

  initial begin
    logic [7:0] r0a, r0b;
    void'($urandom(32'h1f3a_5c07));
    rst_n = 0; lr_we = 0; hcr_we = 0; lr_cpu = 0; lr_idx = 0; lr_wdata = 0;
    hcr_cpu = 0; hcr_wdata = 0; g0 = 0; g1 = 0; rd_cpu = 0;
    for (int c = 0; c < NC; c++) begin
      m_hcr[c] = 0;
      for (int i = 0; i < NL; i++) m_lr[c][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_all("R1 reset state");

    // R3: underflow with 0, 1 and 2 live entries
    wr_hcr(0, 32'h0000_0003);
    check_all("R3 zero live");
    wr_lr(0, 0, mk_lr(0, 2'b10, 0));
    check_all("R3 one live");
    wr_lr(0, 1, mk_lr(0, 2'b11, 0));
    check_all("R3 two live clears");

    // R2: EOI entry, blocked by hw flag or live state; ungated by control
    wr_hcr(0, 32'h0);
    wr_lr(0, 2, mk_lr(1, 2'b00, 1));
    check_all("R2 hw blocks");
    wr_lr(0, 2, mk_lr(0, 2'b10, 1));
    check_all("R2 live blocks");
    wr_lr(0, 2, mk_lr(0, 2'b00, 1));
    check_all("R2 eoi ungated, R7 no global");
    wr_hcr(0, 32'h0000_0001);
    check_all("R7 level high");
    repeat (5) @(negedge clk);
    check_all("R7 level holds");

    // R4: count field
    wr_hcr(1, 32'h0000_0005);
    check_all("R4 count zero");
    wr_hcr(1, 32'h0800_0005);
    check_all("R4 count one, R10 cpu0 intact");

    // R5: pending vs pending+active
    wr_hcr(1, 32'h0000_0009);
    check_all("R5 empty");
    wr_lr(1, 3, mk_lr(0, 2'b11, 0));
    check_all("R5 pend+active not pending");
    wr_lr(1, 3, mk_lr(0, 2'b01, 0));
    check_all("R5 pending present");

    // R6: group enables both polarities
    wr_hcr(1, 32'h0000_00F1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); g0[1] = k[0]; g1[1] = k[1];
      check_all("R6 group toggle");
    end

    // R8: no write leaves state alone; R9: reads have no side effect
    @(negedge clk);
    hcr_wdata = 32'hFFFF_FFFF; lr_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_all("R8 no write holds");
    rd_cpu = 0; #1; r0a = rd_status;
    rd_cpu = 1; #1;
    rd_cpu = 0; #1; r0b = rd_status;
    n_checks++;
    if (r0a !== r0b) begin
      n_fail++;
      $display("FAIL R9 reread: actual=%02h expected=%02h", r0b, r0a);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 5) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom_range(0, 1)) d[29:28] = 2'b00;
        wr_lr($urandom_range(0, NC-1), $urandom_range(0, NL-1), d);
      end else if (sel < 8) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom_range(0, 2) == 0) d[31:27] = 0;
        wr_hcr($urandom_range(0, NC-1), d);
      end else begin
        @(negedge clk); g0 = NC'($urandom); g1 = NC'($urandom);
      end
      check_all("random R8 R10");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule